// File: doc/BRIEF.md
# Pin Pulse-Width Power and Reset Controller

This block watches one active-low power-control pin and decides, from how long the pin stays low, which of two commands it carries. A short low pulse clears every internal register. A long low pulse shuts the device down. The pin is asynchronous to the sample clock, so it first passes through a two-flop synchronizer. The block then counts low time in clock cycles, against thresholds that are derived from nanosecond parameters and the clock frequency.

After a power-on reset, and again after the pin is released from power-down, the block runs a power-up wait. The wait length is set by parameters for the internal-reference case and the external-reference case. Until that wait expires, the ready flag stays low and control-register writes are dropped, and each dropped write is answered with a reject pulse. The control register resets to all zeros, which selects the internal reference and normal mode. Bit 3 of the register enables temperature averaging, and an accumulator elsewhere is told to clear when power-down is entered while that bit is set.

At the defaults (100 MHz sample clock, 20 ns minimum reset width, 100 ns power-down threshold, 100 us wait), a pulse is measured in sampled low cycles. A 1-cycle pulse is a glitch, 2 to 10 cycles is a reset, and 11 or more cycles is power-down.

Top module: `pinpulse_pwr_ctrl`

## Requirements
- R1: While and directly after `rst`, `ctrl_reg` is all zeros, `ready` is 0 and `powered_down` is 0.
- R2: `ready` rises exactly PUP_CYC clock edges after the wait starts (10000 at defaults). A write presented on the last waiting edge is rejected, and one presented on the next edge is accepted.
- R3: A write while `ready` is 0 leaves `ctrl_reg` unchanged and produces a one-cycle `wr_rej` pulse. A write while `ready` is 1 loads `wr_data` into `ctrl_reg` with no reject.
- R4: A low pulse shorter than the minimum reset width (1 cycle at defaults) is ignored: `ctrl_reg` is kept, no `reg_clr` pulse occurs, and `ready` returns to 1.
- R5: A low pulse from the minimum width up to and including the power-down threshold (2 to 10 cycles) clears `ctrl_reg` to zero on release. It also gives exactly one `reg_clr` pulse, does not assert `powered_down`, and `ready` returns to 1.
- R6: A low level longer than the threshold (11 or more cycles) asserts `powered_down` while the pin is still low, clears `ctrl_reg`, drops `ready` and pulses `reg_clr` once.
- R7: On power-down entry, `avg_rst` pulses once if bit 3 of `ctrl_reg` (averaging enable) was 1, and does not pulse if it was 0.
- R8: Driving the pin high in power-down clears `powered_down` within a few cycles and starts a fresh power-up wait, after which `ready` returns to 1 and writes are accepted again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running sample clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| pd_pin_n | input | 1 | Asynchronous active-low power/reset pin |
| wr_en | input | 1 | Control-register write strobe |
| wr_data | input | CREG_W | Control-register write value |
| ctrl_reg | output | CREG_W | Current control-register contents |
| reg_clr | output | 1 | One-cycle pulse when registers are cleared |
| avg_rst | output | 1 | One-cycle pulse to clear the averaging accumulator |
| powered_down | output | 1 | High while in full power-down |
| ready | output | 1 | High when register writes are accepted |
| wr_rej | output | 1 | One-cycle pulse for a dropped write |

## Verification
The expiry of the power-up counter and a register write can land on the same clock edge. The bench aims a write at the very last waiting edge, counted from the release of reset, and expects a reject with `ctrl_reg` unchanged. It then writes one edge later and expects the value to load with no new reject. Pulse widths on either side of both thresholds (1, 2, 10 and 11 cycles) are judged by `ctrl_reg`, by the reject, clear and averaging pulse counts, and by `ready` once the pulse has settled.

// File: rtl/pwrpin_pkg.sv
package pwrpin_pkg;
  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_PUP   = 2'd1,
    ST_READY = 2'd2,
    ST_MEAS  = 2'd3
  } pwr_state_t;

  // nanoseconds to clock cycles, rounded up
  function automatic int ns_to_cyc(input int ns, input int clk_mhz);
    return (ns * clk_mhz + 999) / 1000;
  endfunction
endpackage

// File: rtl/pwrpin_sync.sv
module pwrpin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sh_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sh_q[0] <= 1'b1;
          else     sh_q[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sh_q[g] <= 1'b1;
          else     sh_q[g] <= sh_q[g-1];
        end
      end
    end
  endgenerate

  assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/pwrpin_low_timer.sv
module pwrpin_low_timer #(
  parameter int MIN_CYC = 2,
  parameter int PD_CYC  = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_s,
  output logic short_evt,
  output logic glitch_evt,
  output logic long_evt
);
  localparam int CNT_W = $clog2(PD_CYC + 2);
  localparam logic [CNT_W-1:0] MIN_C = CNT_W'(MIN_CYC);
  localparam logic [CNT_W-1:0] PD_C  = CNT_W'(PD_CYC);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= '0;
      short_evt  <= 1'b0;
      glitch_evt <= 1'b0;
      long_evt   <= 1'b0;
    end else begin
      short_evt  <= 1'b0;
      glitch_evt <= 1'b0;
      long_evt   <= 1'b0;
      if (!pin_s) begin
        if (cnt_q <= PD_C) cnt_q <= cnt_q + 1'b1;
        long_evt <= (cnt_q == PD_C);
      end else begin
        cnt_q <= '0;
        if (cnt_q != '0) begin
          short_evt  <= (cnt_q >= MIN_C) && (cnt_q <= PD_C);
          glitch_evt <= (cnt_q < MIN_C);
        end
      end
    end
  end

  // R4
  evt_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({short_evt, glitch_evt, long_evt}));

  // R6
  long_once_chk: assert property (@(posedge clk) disable iff (rst)
    long_evt |=> !long_evt);
endmodule

// File: rtl/pwrpin_fsm.sv
module pwrpin_fsm
  import pwrpin_pkg::*;
#(
  parameter int CREG_W  = 16,
  parameter int AVG_BIT = 3,
  parameter int PUP_CYC = 10000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pin_s,
  input  logic              short_evt,
  input  logic              glitch_evt,
  input  logic              long_evt,
  input  logic              wr_en,
  input  logic [CREG_W-1:0] wr_data,
  output logic [CREG_W-1:0] ctrl_q,
  output logic              reg_clr,
  output logic              avg_rst,
  output logic              powered_down,
  output logic              ready,
  output logic              wr_rej
);
  localparam int PUP_W = $clog2(PUP_CYC + 1);
  localparam logic [PUP_W-1:0] PUP_LAST = PUP_W'(PUP_CYC - 1);

  pwr_state_t       state_q, nxt;
  logic [PUP_W-1:0] pup_q;
  logic             ret_ready_q;

  always_comb begin
    nxt = state_q;
    unique case (state_q)
      ST_OFF:   if (pin_s) nxt = ST_PUP;
      ST_PUP:   if (!pin_s) nxt = ST_MEAS;
                else if (pup_q == PUP_LAST) nxt = ST_READY;
      ST_READY: if (!pin_s) nxt = ST_MEAS;
      ST_MEAS:  if (long_evt) nxt = ST_OFF;
                else if (short_evt || glitch_evt)
                  nxt = ret_ready_q ? ST_READY : ST_PUP;
      default:  nxt = ST_PUP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_PUP;
      pup_q        <= '0;
      ret_ready_q  <= 1'b0;
      ctrl_q       <= '0;
      reg_clr      <= 1'b0;
      avg_rst      <= 1'b0;
      powered_down <= 1'b0;
      ready        <= 1'b0;
      wr_rej       <= 1'b0;
    end else begin
      state_q      <= nxt;
      ready        <= (nxt == ST_READY);
      powered_down <= (nxt == ST_OFF);
      reg_clr      <= 1'b0;
      avg_rst      <= 1'b0;
      wr_rej       <= 1'b0;
      if (state_q == ST_PUP && nxt == ST_PUP) pup_q <= pup_q + 1'b1;
      if (state_q != ST_MEAS && nxt == ST_MEAS) ret_ready_q <= (state_q == ST_READY);
      if (state_q == ST_MEAS && long_evt) begin
        ctrl_q      <= '0;
        reg_clr     <= 1'b1;
        avg_rst     <= ctrl_q[AVG_BIT];
        pup_q       <= '0;
        ret_ready_q <= 1'b0;
      end else if (state_q == ST_MEAS && short_evt) begin
        ctrl_q  <= '0;
        reg_clr <= 1'b1;
        if (!ret_ready_q) pup_q <= '0;
      end
      if (wr_en) begin
        if (state_q == ST_READY && nxt == ST_READY) ctrl_q <= wr_data;
        else                                         wr_rej <= 1'b1;
      end
    end
  end

  // R6
  pd_clears_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(powered_down) |-> (ctrl_q == '0) && !ready);

  // R3
  rej_needs_wr_chk: assert property (@(posedge clk) disable iff (rst)
    wr_rej |-> $past(wr_en));

  // R3
  ctrl_write_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q != $past(ctrl_q)) |-> ($past(ready) && $past(wr_en)) || (ctrl_q == '0));

  // R7
  avg_with_pd_chk: assert property (@(posedge clk) disable iff (rst)
    avg_rst |-> powered_down && reg_clr);

  // R5
  clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
    reg_clr |-> (ctrl_q == '0));

  // R8
  ready_excl_chk: assert property (@(posedge clk) disable iff (rst)
    ready |-> !powered_down);
endmodule

// File: rtl/pinpulse_pwr_ctrl.sv
module pinpulse_pwr_ctrl
  import pwrpin_pkg::*;
#(
  parameter int CREG_W     = 16,
  parameter int AVG_BIT    = 3,
  parameter int CLK_MHZ    = 100,
  parameter int MIN_RST_NS = 20,
  parameter int PD_NS      = 100,
  parameter int PUP_INT_US = 100,
  parameter int PUP_EXT_US = 50,
  parameter bit EXT_REF    = 1'b0,
  parameter int SYNC_STG   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pd_pin_n,
  input  logic              wr_en,
  input  logic [CREG_W-1:0] wr_data,
  output logic [CREG_W-1:0] ctrl_reg,
  output logic              reg_clr,
  output logic              avg_rst,
  output logic              powered_down,
  output logic              ready,
  output logic              wr_rej
);
  localparam int MIN_CYC = ns_to_cyc(MIN_RST_NS, CLK_MHZ);
  localparam int PD_CYC  = (PD_NS * CLK_MHZ) / 1000;
  localparam int PUP_CYC = (EXT_REF ? PUP_EXT_US : PUP_INT_US) * CLK_MHZ;

  logic pin_s, short_evt, glitch_evt, long_evt;

  pwrpin_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst(rst), .din(pd_pin_n), .dout(pin_s)
  );

  pwrpin_low_timer #(.MIN_CYC(MIN_CYC), .PD_CYC(PD_CYC)) u_timer (
    .clk(clk), .rst(rst), .pin_s(pin_s),
    .short_evt(short_evt), .glitch_evt(glitch_evt), .long_evt(long_evt)
  );

  pwrpin_fsm #(.CREG_W(CREG_W), .AVG_BIT(AVG_BIT), .PUP_CYC(PUP_CYC)) u_fsm (
    .clk(clk), .rst(rst), .pin_s(pin_s),
    .short_evt(short_evt), .glitch_evt(glitch_evt), .long_evt(long_evt),
    .wr_en(wr_en), .wr_data(wr_data), .ctrl_q(ctrl_reg),
    .reg_clr(reg_clr), .avg_rst(avg_rst), .powered_down(powered_down),
    .ready(ready), .wr_rej(wr_rej)
  );
endmodule

// File: tb/test_pinpulse_pwr_ctrl.sv
module test_pinpulse_pwr_ctrl;
  localparam int PUP = 10000;

  logic        clk = 1'b0;
  logic        rst, pin, wr_en;
  logic [15:0] wr_data;
  logic [15:0] ctrl_reg;
  logic        reg_clr, avg_rst, powered_down, ready, wr_rej;

  always #5 clk = ~clk;

  pinpulse_pwr_ctrl i_pinpulse_pwr_ctrl (
    .clk(clk), .rst(rst), .pd_pin_n(pin), .wr_en(wr_en), .wr_data(wr_data),
    .ctrl_reg(ctrl_reg), .reg_clr(reg_clr), .avg_rst(avg_rst),
    .powered_down(powered_down), .ready(ready), .wr_rej(wr_rej)
  );

  typedef struct { string req; string sig; int exp; } item_t;
  item_t q[$];
  int n_vec = 0, n_bad = 0;
  int n_clr = 0, n_avg = 0, n_rej = 0;
  bit done = 1'b0;

  // pulse counters, sampled after each edge
  always @(posedge clk) begin
    #1;
    if (reg_clr) n_clr++;
    if (avg_rst) n_avg++;
    if (wr_rej)  n_rej++;
  end

  function automatic int get_val(string s);
    case (s)
      "ctrl":  return int'(ctrl_reg);
      "ready": return int'(ready);
      "pd":    return int'(powered_down);
      "clr":   return n_clr;
      "avg":   return n_avg;
      "rej":   return n_rej;
      default: return -1;
    endcase
  endfunction

  // driver side: push an expected item
  task automatic expect_v(string req, string sig, int exp);
    item_t it;
    it.req = req; it.sig = sig; it.exp = exp;
    q.push_back(it);
  endtask

  // monitor: pop and compare shortly after each falling edge
  always @(negedge clk) begin
    #2;
    while (q.size() > 0) begin
      item_t it;
      int act;
      it  = q.pop_front();
      act = get_val(it.sig);
      n_vec++;
      if (act != it.exp) begin
        n_bad++;
        $display("FAIL %s %s actual=%0d expected=%0d", it.req, it.sig, act, it.exp);
      end
    end
  end

  task automatic do_write(logic [15:0] v);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pin_low(int n);
    pin = 1'b0;
    repeat (n) @(negedge clk);
    pin = 1'b1;
  endtask

  initial begin
    rst = 1'b1; pin = 1'b1; wr_en = 1'b0; wr_data = '0;
    repeat (3) @(negedge clk);
    expect_v("R1", "ctrl", 0); expect_v("R1", "ready", 0); expect_v("R1", "pd", 0);
    rst = 1'b0;
    // R3: write during power-up, edge 1 after reset
    do_write(16'h00FF);
    repeat (PUP - 2) @(negedge clk);
    expect_v("R2", "ready", 0); expect_v("R3", "rej", 1); expect_v("R3", "ctrl", 0);
    // R2: write on the last waiting edge is rejected
    do_write(16'h00A5);
    expect_v("R2", "ready", 1); expect_v("R2", "rej", 2); expect_v("R2", "ctrl", 0);
    do_write(16'h00A5);
    expect_v("R3", "ctrl", 16'h00A5); expect_v("R3", "rej", 2);
    // R4: 1-cycle glitch
    pin_low(1);
    repeat (8) @(negedge clk);
    expect_v("R4", "ctrl", 16'h00A5); expect_v("R4", "clr", 0); expect_v("R4", "ready", 1);
    // R5: 2-cycle pulse, lower bound
    pin_low(2);
    repeat (8) @(negedge clk);
    expect_v("R5", "ctrl", 0); expect_v("R5", "clr", 1); expect_v("R5", "pd", 0);
    expect_v("R5", "ready", 1);
    // R5: 10-cycle pulse, upper bound, averaging enabled
    do_write(16'h0008);
    pin_low(10);
    repeat (8) @(negedge clk);
    expect_v("R5", "ctrl", 0); expect_v("R5", "clr", 2); expect_v("R5", "pd", 0);
    expect_v("R7", "avg", 0); expect_v("R5", "ready", 1);
    // R6/R7: 11-cycle pulse with averaging off
    do_write(16'h0005);
    pin_low(11);
    repeat (8) @(negedge clk);
    expect_v("R6", "ctrl", 0); expect_v("R6", "clr", 3); expect_v("R7", "avg", 0);
    expect_v("R6", "ready", 0);
    repeat (PUP + 10) @(negedge clk);
    expect_v("R8", "ready", 1);
    // R6/R7: held low, averaging on
    do_write(16'h0008);
    expect_v("R3", "ctrl", 8);
    pin = 1'b0;
    repeat (20) @(negedge clk);
    expect_v("R6", "pd", 1); expect_v("R6", "ready", 0); expect_v("R6", "ctrl", 0);
    expect_v("R6", "clr", 4); expect_v("R7", "avg", 1);
    do_write(16'h0077);
    expect_v("R3", "rej", 3); expect_v("R3", "ctrl", 0);
    // R8: release
    pin = 1'b1;
    repeat (6) @(negedge clk);
    expect_v("R8", "pd", 0); expect_v("R8", "ready", 0);
    repeat (PUP - 20) @(negedge clk);
    expect_v("R8", "ready", 0);
    repeat (30) @(negedge clk);
    expect_v("R8", "ready", 1);
    do_write(16'h1234);
    expect_v("R8", "ctrl", 16'h1234); expect_v("R8", "rej", 3);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule